// File: doc/BRIEF.md
# High Colour Pixel Byte Packer

This block sits between a pattern or frame source and an 8-bit video DAC pixel bus. Each system clock it can take one 15-bit pixel that carries 5 bits each of red, green and blue (32,768 colours). It forms a 16-bit word with a zero in the top bit and sends that word to the DAC as two bytes, low byte first.

The block runs on a byte clock that is twice the system clock rate. A built-in divider marks which byte-clock cycles start a system clock, and it brings that marker out so the source can stay aligned with the block. In dual-edge mode both bytes of a pixel go out within one system clock, so a new pixel can follow on every system clock. In single-edge mode each byte is held for a whole system clock, a pixel takes two system clocks, and the horizontal resolution is halved (for example, 800 timing pixels carry 400 image pixels).

While active video is low the pixel bus is forced to zero, so the bus follows the sync generator's position. A byte-phase output marks which half of the word is on the bus, so a pixel can be rebuilt downstream.

The sequencer has three states. PK_IDLE drives zeros, PK_LOW drives the low byte and PK_HIGH drives the high byte. It has five transitions:

- TR_ACCEPT: a pixel is captured and the state goes to PK_LOW.
- TR_SECOND: the state goes from PK_LOW to PK_HIGH.
- TR_BLANK: active video is low, so the state goes to PK_IDLE.
- TR_STARVE: active video is high but no pixel is offered, so the state goes to PK_IDLE.
- TR_HOLD: nothing changes.

Top module: `hcp_packer`

## Requirements
- R1: The packed word is {1'b0, red[4:0], green[4:0], blue[4:0]}, where red is pix_in[14:10], green is pix_in[9:5] and blue is pix_in[4:0]. The low byte is {green[2:0], blue} and the high byte is {1'b0, red, green[4:3]}, so bit 7 of the high byte is always 0.
- R2: For each pixel the low byte is driven first with byte_phase = 0, and then the high byte with byte_phase = 1.
- R3: In dual-edge mode (dual_mode = 1 when the pixel is taken), the low byte is on pix_bus in the byte clock right after the sampling edge and the high byte in the byte clock after that. Pixels offered on consecutive system clocks appear with no gap between them.
- R4: In single-edge mode (dual_mode = 0 when the pixel is taken), the low byte is held for two byte clocks (one system clock) and then the high byte for two byte clocks.
- R5: In single-edge mode, pix_valid and pix_in are ignored at the system-clock edge where the high byte is due, so a pixel offered there never reaches the bus.
- R6: When active is low at a system-clock edge, pix_bus is 0 with byte_phase = 0 for the whole next system clock. The same holds when active is high but pix_valid is low.
- R7: sys_ce is 1 in every other byte clock, starting with the first byte clock after reset is released. Inputs are sampled only at edges that end a cycle in which sys_ce is 1, and input changes made while sys_ce is 0 have no effect.
- R8: The mode is latched with each pixel. A change of dual_mode while that pixel is in flight does not alter how it is sent.
- R9: While rst_n is low, pix_bus is 0, byte_phase is 0 and sys_ce is 1. A reset in the middle of a pixel discards that pixel.
- R10: In single-edge mode, if active falls at the system-clock edge where the high byte is due, the pixel is dropped and pix_bus goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, twice the system clock rate |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_in | input | 15 | Pixel: red [14:10], green [9:5], blue [4:0] |
| active | input | 1 | Active-video flag from the sync generator |
| pix_valid | input | 1 | A pixel is offered on pix_in |
| dual_mode | input | 1 | 1 for dual-edge mode, 0 for single-edge mode |
| pix_bus | output | 8 | Byte to the video DAC |
| byte_phase | output | 1 | 0 while the low byte is driven, 1 while the high byte is driven |
| sys_ce | output | 1 | Marks a byte clock that begins a system clock |

## Verification
The bench offers a second pixel at the single-edge mid-pixel edge and then withdraws it. A design that samples on odd phases would show that pixel's low byte where zeros belong. It changes inputs only while sys_ce is low, which catches a design that samples on every byte clock. It flips dual_mode while a pixel is in flight: a design that reads the live mode would stall a dual-edge high byte or rush a single-edge one. It also drops active halfway through a single-edge pixel and resets in the middle of a stream, where a design that lets the high byte through would put non-zero data outside active video. Pixels with only red or only green set expose a swapped field or a shifted green split at once.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

    // Byte sequencer states
    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_LOW  = 2'd1,
        PK_HIGH = 2'd2
    } pk_state_e;

    // Named transitions chosen each byte clock
    typedef enum logic [2:0] {
        TR_HOLD   = 3'd0,
        TR_ACCEPT = 3'd1,
        TR_SECOND = 3'd2,
        TR_BLANK  = 3'd3,
        TR_STARVE = 3'd4
    } pk_trans_e;

    localparam int NUM_PRIMARIES = 3;

endpackage

// File: rtl/hcp_slot_gen.sv
module hcp_slot_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sys_ce
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sys_ce = (cnt_q == '0);

endmodule

// File: rtl/hcp_word_pack.sv
module hcp_word_pack #(
    parameter int CW = 5,
    parameter int BW = 8
) (
    input  logic [3*CW-1:0] pix,
    output logic [BW-1:0]   lo_byte,
    output logic [BW-1:0]   hi_byte
);
    import hcp_pkg::*;

    localparam int PIX_W  = NUM_PRIMARIES * CW;
    localparam int WORD_W = 2 * BW;
    localparam int PAD_W  = WORD_W - PIX_W;

    logic [WORD_W-1:0] word;

    // Place each primary in its own field: blue lowest, red highest
    for (genvar c = 0; c < NUM_PRIMARIES; c++) begin : g_field
        assign word[c*CW +: CW] = pix[c*CW +: CW];
    end

    // Spare top bits are sent as zero
    if (PAD_W > 0) begin : g_pad
        assign word[WORD_W-1:PIX_W] = '0;
    end

    assign lo_byte = word[BW-1:0];
    assign hi_byte = word[WORD_W-1:BW];

endmodule

// File: rtl/hcp_byte_fsm.sv
module hcp_byte_fsm #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sys_ce,
    input  logic          active,
    input  logic          pix_valid,
    input  logic          dual_mode,
    input  logic [BW-1:0] lo_in,
    input  logic [BW-1:0] hi_in,
    output logic [BW-1:0] bus,
    output logic          phase,
    output logic          take,
    output logic          mode_q
);
    import hcp_pkg::*;

    pk_state_e state_q, state_d;
    pk_trans_e tr;
    logic [BW-1:0] lo_q, hi_q;

    // Transition choice
    always_comb begin
        tr = TR_HOLD;
        if (sys_ce) begin
            if (!active) begin
                tr = TR_BLANK;
            end else if (state_q == PK_LOW) begin
                // single-edge pixel owes its high byte: inputs ignored
                tr = TR_SECOND;
            end else if (pix_valid) begin
                tr = TR_ACCEPT;
            end else begin
                tr = TR_STARVE;
            end
        end else if (state_q == PK_LOW && mode_q) begin
            // dual-edge: high byte in the second half of the system clock
            tr = TR_SECOND;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (tr)
            TR_HOLD:   state_d = state_q;
            TR_ACCEPT: state_d = PK_LOW;
            TR_SECOND: state_d = PK_HIGH;
            TR_BLANK:  state_d = PK_IDLE;
            TR_STARVE: state_d = PK_IDLE;
            default:   state_d = PK_IDLE;
        endcase
    end

    assign take = (tr == TR_ACCEPT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Pixel capture with its mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            mode_q <= 1'b0;
        end else if (take) begin
            lo_q   <= lo_in;
            hi_q   <= hi_in;
            mode_q <= dual_mode;
        end
    end

    // Outputs from state
    always_comb begin
        bus   = '0;
        phase = 1'b0;
        unique case (state_q)
            PK_IDLE: begin
                bus   = '0;
                phase = 1'b0;
            end
            PK_LOW: begin
                bus   = lo_q;
                phase = 1'b0;
            end
            PK_HIGH: begin
                bus   = hi_q;
                phase = 1'b1;
            end
            default: begin
                bus   = '0;
                phase = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hcp_packer.sv
module hcp_packer #(
    parameter int CW = 5,
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3*CW-1:0] pix_in,
    input  logic            active,
    input  logic            pix_valid,
    input  logic            dual_mode,
    output logic [BW-1:0]   pix_bus,
    output logic            byte_phase,
    output logic            sys_ce
);
    localparam int BYTES_PER_PIX = 2;

    logic [BW-1:0] lo_byte, hi_byte;
    logic          take;
    logic          mode_q;

    hcp_slot_gen #(
        .DIV (BYTES_PER_PIX)
    ) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .sys_ce (sys_ce)
    );

    hcp_word_pack #(
        .CW (CW),
        .BW (BW)
    ) u_pack (
        .pix     (pix_in),
        .lo_byte (lo_byte),
        .hi_byte (hi_byte)
    );

    hcp_byte_fsm #(
        .BW (BW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_ce    (sys_ce),
        .active    (active),
        .pix_valid (pix_valid),
        .dual_mode (dual_mode),
        .lo_in     (lo_byte),
        .hi_in     (hi_byte),
        .bus       (pix_bus),
        .phase     (byte_phase),
        .take      (take),
        .mode_q    (mode_q)
    );

endmodule

// File: rtl/hcp_packer_chk.sv
module hcp_packer_chk #(
    parameter int CW = 5,
    parameter int BW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3*CW-1:0] pix_in,
    input logic            active,
    input logic            pix_valid,
    input logic            dual_mode,
    input logic [BW-1:0]   pix_bus,
    input logic            byte_phase,
    input logic            sys_ce,
    input logic            take
);
    localparam int WORD_W = 2 * BW;

    logic [WORD_W-1:0] w_exp;
    logic [BW-1:0]     w_lo, w_hi;
    logic              past_rst_q;

    assign w_exp = WORD_W'(pix_in);
    assign w_lo  = w_exp[BW-1:0];
    assign w_hi  = w_exp[WORD_W-1:BW];

    always_ff @(posedge clk) begin
        past_rst_q <= !rst_n;
        if (past_rst_q) begin
            assert_reset_quiet_R9: assert (pix_bus == '0 && !byte_phase && sys_ce)
                else $error("bus not quiet after reset");
        end
    end

    assert_ce_alternates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ce |=> !sys_ce);

    assert_take_on_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> sys_ce && active && pix_valid);

    assert_top_bit_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_phase |-> !pix_bus[BW-1]);

    assert_blank_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_ce && !active |=> pix_bus == '0 && !byte_phase);

    assert_dual_bytes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take && dual_mode |=> (!byte_phase && pix_bus == $past(w_lo))
                              ##1 (byte_phase && pix_bus == $past(w_hi, 2)));

    assert_single_low_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take && !dual_mode |=> !byte_phase ##1 !byte_phase);

    assert_single_high_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take && !dual_mode ##2 active |=> byte_phase ##1 byte_phase);

    assert_odd_phase_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take && !dual_mode |=> ##1 !take);

endmodule

bind hcp_packer hcp_packer_chk #(
    .CW (CW),
    .BW (BW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_in     (pix_in),
    .active     (active),
    .pix_valid  (pix_valid),
    .dual_mode  (dual_mode),
    .pix_bus    (pix_bus),
    .byte_phase (byte_phase),
    .sys_ce     (sys_ce),
    .take       (take)
);

// File: tb/tb_hcp_packer.sv
module tb_hcp_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] pix_in = '0;
    logic        active = 1'b0;
    logic        pix_valid = 1'b0;
    logic        dual_mode = 1'b0;
    logic [7:0]  pix_bus;
    logic        byte_phase;
    logic        sys_ce;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    hcp_packer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_in     (pix_in),
        .active     (active),
        .pix_valid  (pix_valid),
        .dual_mode  (dual_mode),
        .pix_bus    (pix_bus),
        .byte_phase (byte_phase),
        .sys_ce     (sys_ce)
    );

    function automatic logic [7:0] lo_of(logic [4:0] r, logic [4:0] g, logic [4:0] b);
        return {g[2:0], b};
    endfunction

    function automatic logic [7:0] hi_of(logic [4:0] r, logic [4:0] g, logic [4:0] b);
        return {1'b0, r, g[4:3]};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic align();
        tick();
        while (sys_ce !== 1'b1) tick();
    endtask

    task automatic offer(logic [4:0] r, logic [4:0] g, logic [4:0] b,
                         logic act, logic val, logic dual);
        pix_in    = {r, g, b};
        active    = act;
        pix_valid = val;
        dual_mode = dual;
    endtask

    task automatic chk(string req, logic [7:0] eb, logic ep);
        checks++;
        if (pix_bus !== eb || byte_phase !== ep) begin
            fails++;
            $display("FAIL %s: bus=%h phase=%b expected bus=%h phase=%b",
                     req, pix_bus, byte_phase, eb, ep);
        end
    endtask

    task automatic chk_ce(string req, logic exp);
        checks++;
        if (sys_ce !== exp) begin
            fails++;
            $display("FAIL %s: sys_ce=%b expected %b", req, sys_ce, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // R9: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        offer(5'h1F, 5'h1F, 5'h1F, 1'b1, 1'b1, 1'b1);
        repeat (3) tick();
        chk("R9 reset bus", 8'h00, 1'b0);
        chk_ce("R9 reset sys_ce", 1'b1);
        offer(5'h0, 5'h0, 5'h0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
    endtask

    // R7: alternation and no sampling while sys_ce is low
    task automatic t_slot();
        align();
        chk_ce("R7 ce high", 1'b1);
        offer(5'h0, 5'h0, 5'h0, 1'b1, 1'b0, 1'b1);
        tick();
        chk_ce("R7 ce low", 1'b0);
        offer(5'h15, 5'h0A, 5'h11, 1'b1, 1'b1, 1'b1);
        tick();
        chk_ce("R7 ce high again", 1'b1);
        offer(5'h15, 5'h0A, 5'h11, 1'b1, 1'b0, 1'b1);
        tick();
        chk("R7 odd-slot offer ignored", 8'h00, 1'b0);
        tick();
        chk("R7 odd-slot offer ignored 2", 8'h00, 1'b0);
    endtask

    // R1, R2, R3: dual-edge stream of back-to-back pixels
    task automatic t_dual_stream();
        align();
        offer(5'h1F, 5'h00, 5'h00, 1'b1, 1'b1, 1'b1);
        tick();
        chk("R1 R2 R3 red-only low", lo_of(5'h1F, 5'h00, 5'h00), 1'b0);
        offer(5'h00, 5'h1F, 5'h00, 1'b1, 1'b1, 1'b1);
        tick();
        chk("R1 R2 R3 red-only high", hi_of(5'h1F, 5'h00, 5'h00), 1'b1);
        tick();
        chk("R1 R3 green-only low no gap", lo_of(5'h00, 5'h1F, 5'h00), 1'b0);
        offer(5'h0C, 5'h13, 5'h1D, 1'b1, 1'b1, 1'b1);
        tick();
        chk("R1 R3 green-only high", hi_of(5'h00, 5'h1F, 5'h00), 1'b1);
        tick();
        chk("R1 R3 mixed low", lo_of(5'h0C, 5'h13, 5'h1D), 1'b0);
        offer(5'h00, 5'h00, 5'h00, 1'b1, 1'b0, 1'b1);
        tick();
        chk("R1 R3 mixed high", hi_of(5'h0C, 5'h13, 5'h1D), 1'b1);
        tick();
        chk("R6 no pixel offered", 8'h00, 1'b0);
    endtask

    // R4, R5: single-edge pixel with an offer on the odd phase
    task automatic t_single();
        align();
        offer(5'h12, 5'h0D, 5'h07, 1'b1, 1'b1, 1'b0);
        tick();
        chk("R4 single low first", lo_of(5'h12, 5'h0D, 5'h07), 1'b0);
        tick();
        chk("R4 single low held", lo_of(5'h12, 5'h0D, 5'h07), 1'b0);
        offer(5'h05, 5'h1A, 5'h1E, 1'b1, 1'b1, 1'b0);
        tick();
        chk("R4 single high first", hi_of(5'h12, 5'h0D, 5'h07), 1'b1);
        offer(5'h00, 5'h00, 5'h00, 1'b1, 1'b0, 1'b0);
        tick();
        chk("R4 single high held", hi_of(5'h12, 5'h0D, 5'h07), 1'b1);
        tick();
        chk("R5 odd-phase pixel dropped", 8'h00, 1'b0);
        tick();
        chk("R5 odd-phase pixel dropped 2", 8'h00, 1'b0);
    endtask

    // R6: blanking
    task automatic t_blank();
        align();
        offer(5'h1F, 5'h1F, 5'h1F, 1'b0, 1'b1, 1'b1);
        tick();
        chk("R6 blank dual a", 8'h00, 1'b0);
        tick();
        chk("R6 blank dual b", 8'h00, 1'b0);
        offer(5'h1F, 5'h1F, 5'h1F, 1'b0, 1'b1, 1'b0);
        tick();
        chk("R6 blank single a", 8'h00, 1'b0);
        tick();
        chk("R6 blank single b", 8'h00, 1'b0);
    endtask

    // R10: active falls mid single-edge pixel
    task automatic t_abort();
        align();
        offer(5'h1F, 5'h1F, 5'h1F, 1'b1, 1'b1, 1'b0);
        tick();
        chk("R10 low before abort", 8'hFF, 1'b0);
        tick();
        offer(5'h1F, 5'h1F, 5'h1F, 1'b0, 1'b1, 1'b0);
        tick();
        chk("R10 high suppressed", 8'h00, 1'b0);
        tick();
        chk("R10 high suppressed 2", 8'h00, 1'b0);
    endtask

    // R8: mode change while a pixel is in flight
    task automatic t_mode_latch();
        align();
        offer(5'h09, 5'h16, 5'h03, 1'b1, 1'b1, 1'b1);
        tick();
        chk("R8 dual low", lo_of(5'h09, 5'h16, 5'h03), 1'b0);
        offer(5'h09, 5'h16, 5'h03, 1'b1, 1'b0, 1'b0);
        tick();
        chk("R8 dual high despite mode flip", hi_of(5'h09, 5'h16, 5'h03), 1'b1);
        offer(5'h1E, 5'h01, 5'h10, 1'b1, 1'b1, 1'b0);
        tick();
        chk("R8 single low", lo_of(5'h1E, 5'h01, 5'h10), 1'b0);
        offer(5'h1E, 5'h01, 5'h10, 1'b1, 1'b0, 1'b1);
        tick();
        chk("R8 single low held despite mode flip", lo_of(5'h1E, 5'h01, 5'h10), 1'b0);
        tick();
        chk("R8 single high", hi_of(5'h1E, 5'h01, 5'h10), 1'b1);
        tick();
        chk("R8 single high held", hi_of(5'h1E, 5'h01, 5'h10), 1'b1);
    endtask

    // R9: reset in mid-stream
    task automatic t_reset_mid();
        align();
        offer(5'h1F, 5'h1F, 5'h1F, 1'b1, 1'b1, 1'b0);
        tick();
        chk("R9 pixel started", 8'hFF, 1'b0);
        rst_n = 1'b0;
        tick();
        chk("R9 mid reset clears", 8'h00, 1'b0);
        chk_ce("R9 mid reset ce", 1'b1);
        offer(5'h0, 5'h0, 5'h0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R9 after release", 8'h00, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_slot();
        t_dual_stream();
        t_single();
        t_blank();
        t_abort();
        t_mode_latch();
        t_reset_mid();
        repeat (4) tick();
        summary();
        $finish;
    end

endmodule